// File: doc/BRIEF.md
# Lookup Memory I/O Cycle Sequencer

This block runs bulk host transfers into and out of a 512-entry lookup memory. The host starts a transfer by pulling an active-low strobe low. A 2-bit operation code then selects whether the transfer reads or writes. An internal address counter starts at entry 0 and advances one entry per clock. Reads stream memory contents onto an output bus with a data-valid flag, after a fixed three-clock latency. Writes store one input-bus word per clock into successive entries.

A transfer is short when the host raises the strobe before every entry has been touched. It is long when it sweeps all 512 entries, and a long transfer stops at the last entry even if the strobe stays low. A transfer-inhibit input stops new transfers from starting. Operation codes whose upper bit is clear start nothing. The memory array is modelled inside the block, and the whole block runs on a single clock.

Top module: `lut_io_seq`

## Requirements
- R1: A transfer starts at the clock edge where start_ni is sampled low after being sampled high on the previous edge, provided inhibit_i is low and op_i[1] is 1. op_i is captured at that edge and held for the whole transfer.
- R2: A falling strobe with inhibit_i high, or with op_i equal to 2'b00 or 2'b01, starts nothing. No entry is written and rd_valid_o stays low.
- R3: The first access of a transfer uses address 0. Each later access uses the previous address plus one, with one access on each clock edge where the transfer is active and start_ni is sampled low.
- R4: With op code 2'b10 (read), rd_data_o carries the contents of entry j for the j-th access, counting from 0. If the start edge is edge k, the first valid word is present after edge k+3.
- R5: With op code 2'b11 (write), the wr_data_i value sampled at edge k+1+j is stored in entry j.
- R6: A short transfer ends at the first edge of an active transfer where start_ni is sampled high. That edge performs no access, so a strobe held low for n edges after the start edge gives exactly n accesses (n < 512).
- R7: A long transfer performs exactly 512 accesses and then stops without wrapping, even while start_ni stays low. A new transfer needs a new falling strobe.
- R8: rd_valid_o is high for exactly as many consecutive clocks as a read transfer made accesses, then falls. While rd_valid_o is low, rd_data_o is all zeros.
- R9: While rst_ni is low, the block is idle and rd_valid_o and rd_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_ni | input | 1 | Active-low transfer strobe |
| inhibit_i | input | 1 | Blocks new transfers while high |
| op_i | input | 2 | Operation code: 2'b10 read, 2'b11 write, 2'b0x none |
| wr_data_i | input | DATA_W | Write data, one word per clock |
| rd_data_o | output | DATA_W | Read data, zero when not valid |
| rd_valid_o | output | 1 | Read data valid |

## Verification
A full 512-entry write followed by a full read, both with the strobe held past the end, shows both sequential addressing and the stop without wrap. Any wrap or skipped address would corrupt a value or the word count. Short writes and reads of different lengths, including a single-entry read, show where the cycle ends and that no extra access happens on the terminating edge. Blocked transfers (inhibit high, codes 2'b00 and 2'b01) come before a read-back, so any stray write shows up as a changed entry and any stray read as an unexpected valid word.

// File: rtl/lut_io_pkg.sv
package lut_io_pkg;
  parameter int unsigned RD_LAT = 3;

  typedef enum logic [1:0] {
    OP_NONE0 = 2'b00,
    OP_NONE1 = 2'b01,
    OP_RD    = 2'b10,
    OP_WR    = 2'b11
  } io_op_e;
endpackage

// File: rtl/lut_io_edge.sv
module lut_io_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= strobe_ni;
  end

  assign fall_o = prev_q & ~strobe_ni;
endmodule

// File: rtl/lut_io_addr_ctrl.sv
module lut_io_addr_ctrl
  import lut_io_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              start_ni,
  input  logic              inhibit_i,
  input  logic [1:0]        op_i,
  output logic              active_o,
  output logic              acc_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output io_op_e            op_o
);
  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  io_op_e            op_q;
  logic              launch;
  logic              last_addr;

  assign launch    = ~active_q & fall_i & ~inhibit_i & op_i[1];
  assign acc_en_o  = active_q & ~start_ni;
  assign last_addr = (addr_q == ADDR_W'(DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      op_q     <= OP_NONE0;
    end else if (launch) begin
      active_q <= 1'b1;
      addr_q   <= '0;
      op_q     <= io_op_e'(op_i);
    end else if (active_q) begin
      if (start_ni) begin
        active_q <= 1'b0;            // short cycle ends, no access
      end else begin
        addr_q <= addr_q + ADDR_W'(1);
        if (last_addr) active_q <= 1'b0;  // long cycle, no wrap
      end
    end
  end

  assign active_o = active_q;
  assign addr_o   = addr_q;
  assign op_o     = op_q;
endmodule

// File: rtl/lut_io_mem.sv
module lut_io_mem #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o  <= rd_en_i;
      rd_data_o <= rd_en_i ? mem_q[addr_i] : '0;
    end
  end
endmodule

// File: rtl/lut_io_rd_pipe.sv
module lut_io_rd_pipe #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  logic              vld_q  [STAGES+1];
  logic [DATA_W-1:0] data_q [STAGES+1];

  assign vld_q[0]  = vld_i;
  assign data_q[0] = vld_i ? data_i : '0;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]  <= 1'b0;
        data_q[s] <= '0;
      end else begin
        vld_q[s]  <= vld_q[s-1];
        data_q[s] <= vld_q[s-1] ? data_q[s-1] : '0;
      end
    end
  end

  assign vld_o  = vld_q[STAGES];
  assign data_o = data_q[STAGES];
endmodule

// File: rtl/lut_io_seq.sv
module lut_io_seq
  import lut_io_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ni,
  input  logic              inhibit_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic              strobe_fall;
  logic              cyc_active;
  logic              acc_en;
  logic [ADDR_W-1:0] cyc_addr;
  io_op_e            cyc_op;
  logic              mem_vld;
  logic [DATA_W-1:0] mem_data;

  lut_io_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_ni(start_ni),
    .fall_o   (strobe_fall)
  );

  lut_io_addr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (strobe_fall),
    .start_ni (start_ni),
    .inhibit_i(inhibit_i),
    .op_i     (op_i),
    .active_o (cyc_active),
    .acc_en_o (acc_en),
    .addr_o   (cyc_addr),
    .op_o     (cyc_op)
  );

  lut_io_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (acc_en && cyc_op == OP_RD),
    .wr_en_i  (acc_en && cyc_op == OP_WR),
    .addr_i   (cyc_addr),
    .wr_data_i(wr_data_i),
    .rd_vld_o (mem_vld),
    .rd_data_o(mem_data)
  );

  // memory read register is the first latency stage
  lut_io_rd_pipe #(.DATA_W(DATA_W), .STAGES(RD_LAT - 1)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (mem_vld),
    .data_i(mem_data),
    .vld_o (rd_valid_o),
    .data_o(rd_data_o)
  );
endmodule

// File: rtl/lut_io_seq_chk.sv
module lut_io_seq_chk
  import lut_io_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_ni,
  input logic              inhibit_i,
  input logic [1:0]        op_i,
  input logic              fall_i,
  input logic              active_i,
  input logic              acc_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input io_op_e            op_q_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o
);
  a_r1_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && fall_i && !inhibit_i && op_i[1]) |=> (active_i && addr_i == '0));

  a_r2_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && fall_i && (inhibit_i || !op_i[1])) |=> !active_i);

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> (!active_i || addr_i == $past(addr_i) + ADDR_W'(1)));

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && op_q_i == OP_RD) |-> ##3 rd_valid_o);

  a_r5_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && op_q_i == OP_WR) |-> ##3 !rd_valid_o);

  a_r6_short_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && start_ni) |=> !active_i);

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && addr_i == ADDR_W'(DEPTH - 1)) |=> !active_i);

  a_r8_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_data_o == '0);
endmodule

bind lut_io_seq lut_io_seq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_ni  (start_ni),
  .inhibit_i (inhibit_i),
  .op_i      (op_i),
  .fall_i    (strobe_fall),
  .active_i  (cyc_active),
  .acc_en_i  (acc_en),
  .addr_i    (cyc_addr),
  .op_q_i    (cyc_op),
  .rd_data_o (rd_data_o),
  .rd_valid_o(rd_valid_o)
);

// File: tb/tb_lut_io_seq.sv
module tb_lut_io_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_ni = 1'b1;
  logic          inhibit_i = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          rd_valid_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_first = 0;
  int vld_cnt = 0;
  logic prev_vld = 1'b0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lut_io_seq #(.DEPTH(DEPTH), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_ni(start_ni), .inhibit_i(inhibit_i),
    .op_i(op_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard pop and timing
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rd_valid_o) begin
        if (vld_cnt == 0)
          chk(cyc == exp_first + 3, "R4", "first valid cycle", cyc, exp_first + 3);
        else if (!prev_vld)
          chk(1'b0, "R8", "valid not contiguous", 0, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected valid word", int'(rd_data_o), -1);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rd_data_o == e, "R4", "read word", int'(rd_data_o), int'(e));
        end
        vld_cnt++;
      end else if (rd_data_o != '0) begin
        chk(1'b0, "R8", "data not zero while invalid", int'(rd_data_o), 0);
      end
    end
    prev_vld = rd_valid_o;
  end

  function automatic logic [DW-1:0] pat(input int seed, input int j);
    return DW'(j * 37 + seed * 1009 + (j >> 3));
  endfunction

  // driver: strobe low for n edges after the start edge
  task automatic run_cycle(input logic [1:0] op, input int n, input logic inh, input int seed, input string req);
    bit acc;
    int m;
    acc = !inh && op[1];
    m = acc ? ((n < DEPTH) ? n : DEPTH) : 0;
    @(negedge clk);
    op_i = op;
    inhibit_i = inh;
    start_ni = 1'b0;
    exp_first = cyc + 1;
    vld_cnt = 0;
    if (acc && op == 2'b10)
      for (int j = 0; j < m; j++) exp_q.push_back(model[j]);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      wr_data_i = pat(seed, j);
      if (acc && op == 2'b11 && j < DEPTH) model[j] = pat(seed, j);
    end
    @(negedge clk);
    start_ni = 1'b1;
    inhibit_i = 1'b0;
    op_i = 2'b00;
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, req, "words outstanding", exp_q.size(), 0);
    chk(vld_cnt == ((acc && op == 2'b10) ? m : 0), req, "valid clock count",
        vld_cnt, (acc && op == 2'b10) ? m : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid_o == 1'b0, "R9", "valid in reset", int'(rd_valid_o), 0);
    chk(rd_data_o == '0, "R9", "data in reset", int'(rd_data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_valid_o == 1'b0, "R9", "valid after reset", int'(rd_valid_o), 0);

    run_cycle(2'b11, 515, 1'b0, 1, "R7");   // R5 long write, strobe held past end
    run_cycle(2'b10, 520, 1'b0, 0, "R7");   // R3 R4 long read, no wrap
    run_cycle(2'b11, 10, 1'b0, 2, "R6");    // R5 short write
    run_cycle(2'b10, 20, 1'b0, 0, "R6");    // R6 short read spanning new and old data
    run_cycle(2'b11, 8, 1'b1, 3, "R2");     // inhibited write
    run_cycle(2'b01, 6, 1'b0, 4, "R2");     // op 01 starts nothing
    run_cycle(2'b00, 6, 1'b0, 5, "R2");     // op 00 starts nothing
    run_cycle(2'b10, 8, 1'b1, 0, "R2");     // inhibited read
    run_cycle(2'b10, 1, 1'b0, 0, "R6");     // single-entry read
    run_cycle(2'b10, 30, 1'b0, 0, "R2");    // read-back after blocked writes
    run_cycle(2'b11, 3, 1'b0, 6, "R5");
    run_cycle(2'b10, 5, 1'b0, 0, "R5");     // R1 back-to-back restart after write

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule